// File: doc/BRIEF.md
# Memory Field Extension Controller

This block widens the reach of a processor that issues 12-bit word addresses. On its own such a processor sees 4096 words. The block splits a 32K-word memory into eight fields of 4096 words each and puts a 3-bit field number in front of every address the processor issues. That gives a 15-bit physical address.

Two field registers are kept. The code field serves instruction fetches and direct operand accesses. The operand field serves indirect operand accesses, so one indirect reference can reach data in any field while the program keeps running in its own field. Both registers are loaded by I/O-transfer instructions that are set aside for bank selection. The processor decodes those instructions and gives the block one strobe per command, together with a 3-bit value.

A new operand field takes effect at once. A new code field is first parked in a pending buffer. It moves into the code field only when the processor executes its next jump or subroutine call, so the jump target is the first word fetched from the new field. A read-back command returns both fields to the processor's accumulator.

Top module: `fext_ctrl`

## Requirements
- R1: After synchronous reset, the code field, operand field and pending buffer are all 0. `phys_valid` and `rb_valid` read 0 from the first edge with `rst` high.
- R2: When `acc_type` is 2'b01 (instruction fetch), `phys_addr` equals {code field, `cpu_addr`} on the following clock edge and `phys_valid` is 1.
- R3: When `acc_type` is 2'b10 (direct operand), `phys_addr` equals {code field, `cpu_addr`} on the following edge and `phys_valid` is 1.
- R4: When `acc_type` is 2'b11 (indirect operand), `phys_addr` equals {operand field, `cpu_addr`} on the following edge and `phys_valid` is 1.
- R5: A pulse on `set_dfld` loads `fld_val` into the operand field. Every access issued in a later cycle uses the new value.
- R6: A pulse on `set_ifld` loads `fld_val` into the pending buffer only. Fetches, direct accesses and read-back keep using the old code field until a jump is executed.
- R7: A pulse on `jump_exec` copies the pending buffer into the code field. Accesses issued in later cycles use the new code field.
- R8: A pulse on `rd_flds` makes `rb_valid` 1 on the next edge, with `rb_data` = {zeros, code field in bits [5:3], operand field in bits [2:0]}. Without the pulse, `rb_valid` is 0.
- R9: When `acc_type` is 2'b00 (no access), `phys_valid` is 0 on the next edge and `phys_addr` keeps its previous value.
- R10: An access, read-back or jump in the same cycle as a field command sees the field values from before that command. A jump in the same cycle as `set_ifld` commits the older buffer value, and the new value waits for the next jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_type | input | 2 | Access kind: 00 none, 01 fetch, 10 direct operand, 11 indirect operand |
| cpu_addr | input | 12 | Processor word address |
| set_ifld | input | 1 | Change-code-field command strobe (loads pending buffer) |
| set_dfld | input | 1 | Change-operand-field command strobe |
| rd_flds | input | 1 | Read-back command strobe |
| jump_exec | input | 1 | Pulse when a jump or subroutine call executes |
| fld_val | input | 3 | Field value carried by the command strobes |
| phys_addr | output | 15 | Registered physical address {field, cpu_addr} |
| phys_valid | output | 1 | phys_addr holds a new access this cycle |
| rb_data | output | 12 | Read-back word: code field [5:3], operand field [2:0] |
| rb_valid | output | 1 | rb_data updated by a read-back |

## Verification
The bench builds the block with its default parameters: 12 address bits and 3 field bits. That configuration is small enough to sweep all 64 pairs of code and operand field. For every pair, the bench walks through the switching sequence: operand change, pending code change, accesses before the jump, the jump itself, then fetch, direct and indirect accesses after it. Both address extremes and a computed mid-range address are used. Same-cycle collisions between commands, accesses and jumps are exercised separately, and expected values come from a small arithmetic model of the three registers.

// File: rtl/fext_pkg.sv
package fext_pkg;
  typedef enum logic [1:0] {
    ACC_NONE     = 2'b00,
    ACC_FETCH    = 2'b01,
    ACC_DIRECT   = 2'b10,
    ACC_INDIRECT = 2'b11
  } acc_e;
endpackage

// File: rtl/fext_field_regs.sv
module fext_field_regs #(
  parameter int FW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_ibuf,
  input  logic          ld_dfld,
  input  logic          commit,
  input  logic [FW-1:0] val,
  output logic [FW-1:0] ifld,
  output logic [FW-1:0] dfld,
  output logic [FW-1:0] ibuf
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ifld <= '0;
      dfld <= '0;
      ibuf <= '0;
    end else begin
      if (commit)  ifld <= ibuf;
      if (ld_ibuf) ibuf <= val;
      if (ld_dfld) dfld <= val;
    end
  end

  AST_IF_WAITS_FOR_JUMP: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(ifld)); // R6
  AST_JUMP_COMMITS_BUF: assert property (@(posedge clk) disable iff (rst)
    commit |=> ifld == $past(ibuf)); // R7
  AST_DF_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
    ld_dfld |=> dfld == $past(val)); // R5
  AST_DF_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !ld_dfld |=> $stable(dfld)); // R5
endmodule

// File: rtl/fext_addr_map.sv
module fext_addr_map
  import fext_pkg::*;
#(
  parameter int AW = 12,
  parameter int FW = 3,
  localparam int PW = AW + FW
) (
  input  logic          clk,
  input  logic          rst,
  input  acc_e          kind,
  input  logic [AW-1:0] addr,
  input  logic [FW-1:0] ifld,
  input  logic [FW-1:0] dfld,
  output logic [PW-1:0] phys,
  output logic          valid
);
  logic [FW-1:0] sel_fld;

  always_comb begin
    sel_fld = (kind == ACC_INDIRECT) ? dfld : ifld;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phys  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= (kind != ACC_NONE);
      if (kind != ACC_NONE) phys <= {sel_fld, addr};
    end
  end

  AST_LOW_BITS_PASS: assert property (@(posedge clk) disable iff (rst)
    (kind != ACC_NONE) |=> phys[AW-1:0] == $past(addr)); // R2
  AST_INDIRECT_DFLD: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_INDIRECT) |=> phys[PW-1:AW] == $past(dfld)); // R4
  AST_DIRECT_IFLD: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_FETCH || kind == ACC_DIRECT) |=> phys[PW-1:AW] == $past(ifld)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (kind == ACC_NONE) |=> !valid && $stable(phys)); // R9
endmodule

// File: rtl/fext_readback.sv
module fext_readback #(
  parameter int AW = 12,
  parameter int FW = 3,
  localparam int PAD = AW - 2 * FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd,
  input  logic [FW-1:0] ifld,
  input  logic [FW-1:0] dfld,
  output logic [AW-1:0] data,
  output logic          valid
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= rd;
      if (rd) data <= {{PAD{1'b0}}, ifld, dfld};
    end
  end

  AST_RB_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd |=> valid && data[FW-1:0] == $past(dfld)); // R8
  AST_RB_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !valid); // R8
endmodule

// File: rtl/fext_ctrl.sv
module fext_ctrl
  import fext_pkg::*;
#(
  parameter int AW = 12,
  parameter int FW = 3,
  localparam int PW = AW + FW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    acc_type,
  input  logic [AW-1:0] cpu_addr,
  input  logic          set_ifld,
  input  logic          set_dfld,
  input  logic          rd_flds,
  input  logic          jump_exec,
  input  logic [FW-1:0] fld_val,
  output logic [PW-1:0] phys_addr,
  output logic          phys_valid,
  output logic [AW-1:0] rb_data,
  output logic          rb_valid
);
  logic [FW-1:0] ifld, dfld, ibuf;
  acc_e          kind;

  assign kind = acc_e'(acc_type);

  fext_field_regs #(.FW(FW)) u_regs (
    .clk(clk), .rst(rst),
    .ld_ibuf(set_ifld), .ld_dfld(set_dfld), .commit(jump_exec),
    .val(fld_val),
    .ifld(ifld), .dfld(dfld), .ibuf(ibuf)
  );

  fext_addr_map #(.AW(AW), .FW(FW)) u_map (
    .clk(clk), .rst(rst),
    .kind(kind), .addr(cpu_addr),
    .ifld(ifld), .dfld(dfld),
    .phys(phys_addr), .valid(phys_valid)
  );

  fext_readback #(.AW(AW), .FW(FW)) u_rb (
    .clk(clk), .rst(rst),
    .rd(rd_flds), .ifld(ifld), .dfld(dfld),
    .data(rb_data), .valid(rb_valid)
  );

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> !phys_valid && !rb_valid && ifld == '0 && dfld == '0 && ibuf == '0); // R1
  AST_SAME_CYCLE_OLD: assert property (@(posedge clk) disable iff (rst)
    (jump_exec && set_ifld) |=> ifld == $past(ibuf)); // R10
endmodule

// File: tb/test_fext_ctrl.sv
`timescale 1ns/1ps
module test_fext_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  acc_type = 2'b00;
  logic [11:0] cpu_addr = '0;
  logic        set_ifld = 1'b0, set_dfld = 1'b0, rd_flds = 1'b0, jump_exec = 1'b0;
  logic [2:0]  fld_val = '0;
  logic [14:0] phys_addr;
  logic        phys_valid;
  logic [11:0] rb_data;
  logic        rb_valid;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [2:0]  m_if = '0, m_df = '0, m_ib = '0;
  logic [14:0] m_last = '0;

  always #5 clk = ~clk;

  fext_ctrl i_fext_ctrl (
    .clk(clk), .rst(rst), .acc_type(acc_type), .cpu_addr(cpu_addr),
    .set_ifld(set_ifld), .set_dfld(set_dfld), .rd_flds(rd_flds),
    .jump_exec(jump_exec), .fld_val(fld_val),
    .phys_addr(phys_addr), .phys_valid(phys_valid),
    .rb_data(rb_data), .rb_valid(rb_valid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] typ, input logic [11:0] a,
                      input logic ci, input logic cd, input logic rd, input logic jp,
                      input logic [2:0] v, input string tag);
    logic [14:0] exp_phys;
    @(negedge clk);
    acc_type = typ; cpu_addr = a; set_ifld = ci; set_dfld = cd;
    rd_flds = rd; jump_exec = jp; fld_val = v;
    @(posedge clk);
    #1;
    acc_type = 2'b00; set_ifld = 0; set_dfld = 0; rd_flds = 0; jump_exec = 0;
    if (typ == 2'b00) begin
      check({tag, " idle valid"}, {31'd0, phys_valid}, 32'd0);
      check({tag, " idle hold"}, {17'd0, phys_addr}, {17'd0, m_last});
    end else begin
      exp_phys = (typ == 2'b11) ? {m_df, a} : {m_if, a};
      check({tag, " valid"}, {31'd0, phys_valid}, 32'd1);
      check({tag, " phys"}, {17'd0, phys_addr}, {17'd0, exp_phys});
      m_last = exp_phys;
    end
    if (rd) begin
      check({tag, " rb_valid"}, {31'd0, rb_valid}, 32'd1);
      check({tag, " rb_data"}, {20'd0, rb_data}, {26'd0, m_if, m_df});
    end else begin
      check({tag, " rb_quiet"}, {31'd0, rb_valid}, 32'd0);
    end
    if (jp) m_if = m_ib;
    if (ci) m_ib = v;
    if (cd) m_df = v;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 phys_valid after reset", {31'd0, phys_valid}, 32'd0);
    check("R1 rb_valid after reset", {31'd0, rb_valid}, 32'd0);
    @(negedge clk);
    rst = 0;
    // R1: fields are zero after reset
    step(2'b00, 12'h000, 0, 0, 1, 0, 3'd0, "R1 readback");
    step(2'b01, 12'hABC, 0, 0, 0, 0, 3'd0, "R1 fetch field0");
    step(2'b11, 12'h123, 0, 0, 0, 0, 3'd0, "R1 indirect field0");
    // R7: jump with empty buffer keeps field 0
    step(2'b00, 12'h000, 0, 0, 0, 1, 3'd0, "R7 jump zero buf");

    for (int f = 0; f < 8; f++) begin
      for (int d = 0; d < 8; d++) begin
        logic [11:0] am;
        am = 12'((f * 611 + d * 97 + 5) % 4096);
        step(2'b00, 12'h000, 0, 1, 0, 0, 3'(d), "R5 set dfld");
        step(2'b11, am, 0, 0, 0, 0, 3'd0, "R5 R4 indirect new dfld");
        step(2'b00, 12'h000, 1, 0, 0, 0, 3'(f), "R6 set ifld");
        step(2'b01, 12'hFFF, 0, 0, 0, 0, 3'd0, "R6 fetch before jump");
        step(2'b10, am, 0, 0, 1, 0, 3'd0, "R6 direct and readback before jump");
        step(2'b00, 12'h000, 0, 0, 0, 1, 3'd0, "R7 jump");
        step(2'b01, am, 0, 0, 0, 0, 3'd0, "R7 R2 fetch after jump");
        step(2'b10, 12'h000, 0, 0, 0, 0, 3'd0, "R3 direct");
        step(2'b11, 12'hFFF, 0, 0, 0, 0, 3'd0, "R4 indirect");
        step(2'b00, 12'h555, 0, 0, 1, 0, 3'd0, "R9 R8 idle readback");
      end
    end

    // R10: same-cycle collisions
    step(2'b00, 12'h000, 1, 1, 0, 0, 3'd2, "R10 both cmds");
    step(2'b11, 12'h321, 0, 1, 1, 0, 3'd5, "R10 indirect with set_dfld");
    step(2'b01, 12'h0F0, 1, 0, 1, 1, 3'd6, "R10 fetch+jump+set_ifld");
    step(2'b01, 12'h0F1, 0, 0, 1, 0, 3'd0, "R10 after jump old buf");
    step(2'b00, 12'h000, 0, 0, 0, 1, 3'd0, "R10 second jump");
    step(2'b10, 12'h777, 0, 0, 1, 0, 3'd0, "R10 new buf committed");
    step(2'b00, 12'h000, 0, 0, 0, 0, 3'd0, "R9 idle");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule